// File: doc/BRIEF.md
# Configuration Register Bank with Selective Reset

This block is the host-facing settings store for a FIFO controller that moves data in two directions, called A-to-B and B-to-A. It holds eight 16-bit configuration words. Words 0 to 3 are almost-empty and almost-full offsets. Word 4 routes internal flags to external pins and comes out of a full reset as 16'h6420, not zero. Words 5 to 7 are general control. The block keeps the DMA direction bit and an internal DMA request bit, and it assembles a read-only status word from the eight FIFO flags that the flag logic drives in.

Software can issue a 3-bit reset command. Each command code clears only its own slice of state: the pointers of one direction, the pointers of both directions, the DMA request, or everything. The controller's pointer logic learns of a pointer clear through two registered strobes, one for each direction. An active-low asynchronous hardware reset restores everything. Reads are combinational and have no side effects. Writes and commands take effect on the rising clock edge.

Top module: `cfgRegBank`

## Requirements
- R1: While `rstN` is low, words 0-3 and 5-7 read 16'h0000 and word 4 reads 16'h6420. `dmaDir` is 0, which means B-to-A write. `dmaReq` is 0. `clrAbPtr` and `clrBaPtr` are both 1, and they stay 1 until the first rising edge after `rstN` goes high.
- R2: When `wrEn` is high and no reset-all is issued, the edge stores `wrData` into word `addr`. Words 0-3 keep only their low OFFSET_W bits (10 by default), and their upper bits read 0.
- R3: Code 3'b001 (with `swRstValid`) drives `clrBaPtr` high for exactly the next cycle, with `clrAbPtr` low.
- R4: Code 3'b010 drives `clrAbPtr` high for exactly the next cycle, with `clrBaPtr` low.
- R5: Code 3'b011 drives both strobes high for exactly the next cycle.
- R6: Code 3'b100 clears `dmaReq` at the edge. It raises no strobe and leaves `dmaDir` unchanged. The clear wins over a `dmaReqSet` in the same cycle.
- R7: Code 3'b111 restores all words to their R1 values, clears `dmaReq` and `dmaDir`, and pulses both strobes for one cycle. It wins over a write or a direction load in the same cycle.
- R8: Codes 3'b000, 3'b101 and 3'b110 have no effect.
- R9: With `rdStatus` high, `rdData` is the status word. Its bits are: bit 3 = `dmaDir`, bit 4 = A-to-B empty, bit 5 = A-to-B almost-empty, bit 6 = B-to-A full, bit 7 = B-to-A almost-full, bit 12 = A-to-B full, bit 13 = A-to-B almost-full, bit 14 = B-to-A empty, bit 15 = B-to-A almost-empty. All other bits read 0. The `flagIn` bits, 0 to 7, are: A-to-B empty, almost-empty, full, almost-full, then B-to-A empty, almost-empty, full, almost-full.
- R10: With `rdStatus` low, `rdData` is word `addr`. Reading changes no state.
- R11: `dmaReqSet` sets `dmaReq`, which then holds until it is cleared. `dmaDirLoad` loads `dmaDirIn` into `dmaDir`.
- R12: Codes 001, 010, 011 and 100 leave all eight words unchanged. A write issued in the same cycle as one of these codes still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Write the selected word |
| addr | input | 3 | Word select for reads and writes |
| wrData | input | 16 | Write data |
| swRstValid | input | 1 | Software reset command valid |
| swRstCode | input | 3 | Software reset command code |
| dmaReqSet | input | 1 | Raise the internal DMA request |
| dmaDirLoad | input | 1 | Load the DMA direction |
| dmaDirIn | input | 1 | DMA direction to load |
| flagIn | input | 8 | FIFO flags from the flag logic |
| rdStatus | input | 1 | Read the status word instead of a configuration word |
| rdData | output | 16 | Read data |
| cfgFlat | output | 128 | All eight words; word i sits at bits 16*i+15 : 16*i |
| dmaReq | output | 1 | Internal DMA request |
| dmaDir | output | 1 | DMA direction (0 = B-to-A write) |
| clrAbPtr | output | 1 | Clear A-to-B pointers |
| clrBaPtr | output | 1 | Clear B-to-A pointers |

## Verification
The bench issues a reset-all in the same cycle as a write and as a direction load. A design that gives the write priority would leave a nonzero word, or a stale direction, after the reset. It also issues the DMA-request clear in the same cycle as a set; a design with the wrong priority would leave `dmaReq` high. Partial codes are mixed with writes to confirm that the write still lands and that no other word moves. The unused codes 101 and 110 are issued to catch a decoder that treats them as reset-all. Offset words are written with all ones to catch upper bits that are stored. Random flag patterns are read through the status word, which exposes any swapped or reserved bit. Finally, the strobes are checked across the hardware reset release, where a design that drops them too early would fail to clear the pointers.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int NUM_REGS        = 8;
  localparam int ADDR_W          = $clog2(NUM_REGS);
  localparam int REG_W           = 16;
  localparam int NUM_OFFSET_REGS = 4;
  localparam int ROUTE_REG_IDX   = 4;
  localparam int NUM_FLAGS       = 8;

  // flag input positions
  localparam int FLG_AB_EMPTY   = 0;
  localparam int FLG_AB_AEMPTY  = 1;
  localparam int FLG_AB_FULL    = 2;
  localparam int FLG_AB_AFULL   = 3;
  localparam int FLG_BA_EMPTY   = 4;
  localparam int FLG_BA_AEMPTY  = 5;
  localparam int FLG_BA_FULL    = 6;
  localparam int FLG_BA_AFULL   = 7;

  typedef enum logic [2:0] {
    SRST_NONE   = 3'b000,
    SRST_BA     = 3'b001,
    SRST_AB     = 3'b010,
    SRST_BOTH   = 3'b011,
    SRST_DMAREQ = 3'b100,
    SRST_ALL    = 3'b111
  } srstCode_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] regWrEn;
    logic                restoreAll;
    logic                clrAbPtr;
    logic                clrBaPtr;
    logic                clrDmaReq;
    logic                setDmaReq;
    logic                loadDmaDir;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfgbank_ctrl.sv
module cfgbank_ctrl
  import cfgbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              swRstValid,
  input  logic [2:0]        swRstCode,
  input  logic              dmaReqSet,
  input  logic              dmaDirLoad,
  output ctrlStrobe_t       strobe,
  output logic              clrAbPtr,
  output logic              clrBaPtr
);
  logic isAll;
  logic isBa;
  logic isAb;
  logic isBoth;
  logic isReq;

  assign isAll  = swRstValid && (swRstCode == SRST_ALL);
  assign isBa   = swRstValid && (swRstCode == SRST_BA);
  assign isAb   = swRstValid && (swRstCode == SRST_AB);
  assign isBoth = swRstValid && (swRstCode == SRST_BOTH);
  assign isReq  = swRstValid && (swRstCode == SRST_DMAREQ);

  // per-word write decode; reset-all suppresses writes
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wrDec
    assign strobe.regWrEn[i] = wrEn && (addr == ADDR_W'(i)) && !isAll;
  end

  assign strobe.restoreAll = isAll;
  assign strobe.clrBaPtr   = isBa || isBoth || isAll;
  assign strobe.clrAbPtr   = isAb || isBoth || isAll;
  assign strobe.clrDmaReq  = isReq || isAll;
  assign strobe.setDmaReq  = dmaReqSet;
  assign strobe.loadDmaDir = dmaDirLoad && !isAll;

  // pointer-clear strobes: high through hardware reset, then one cycle per command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrAbPtr <= 1'b1;
      clrBaPtr <= 1'b1;
    end else begin
      clrAbPtr <= strobe.clrAbPtr;
      clrBaPtr <= strobe.clrBaPtr;
    end
  end
endmodule

// File: rtl/cfgbank_data.sv
module cfgbank_data
  import cfgbank_pkg::*;
#(
  parameter int               OFFSET_W      = 10,
  parameter logic [REG_W-1:0] ROUTE_DEFAULT = 16'h6420
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [REG_W-1:0]          wrData,
  input  logic                      dmaDirIn,
  input  logic [NUM_FLAGS-1:0]      flagIn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rdStatus,
  output logic [REG_W-1:0]          rdData,
  output logic [NUM_REGS*REG_W-1:0] cfgFlat,
  output logic                      dmaReq,
  output logic                      dmaDir
);
  localparam int PAD_W = REG_W - OFFSET_W;

  logic [REG_W-1:0] regVal [NUM_REGS];
  logic [REG_W-1:0] statusWord;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i < NUM_OFFSET_REGS) begin : g_off
      logic [OFFSET_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   q <= '0;
        else if (strobe.restoreAll)  q <= '0;
        else if (strobe.regWrEn[i])  q <= wrData[OFFSET_W-1:0];
      end
      assign regVal[i] = {{PAD_W{1'b0}}, q};
    end else begin : g_full
      localparam logic [REG_W-1:0] RST_VAL = (i == ROUTE_REG_IDX) ? ROUTE_DEFAULT : '0;
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                   q <= RST_VAL;
        else if (strobe.restoreAll)  q <= RST_VAL;
        else if (strobe.regWrEn[i])  q <= wrData;
      end
      assign regVal[i] = q;
    end
    assign cfgFlat[i*REG_W +: REG_W] = regVal[i];
  end

  // DMA request: any clear beats a set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                      dmaReq <= 1'b0;
    else if (strobe.restoreAll || strobe.clrDmaReq) dmaReq <= 1'b0;
    else if (strobe.setDmaReq)                      dmaReq <= 1'b1;
  end

  // DMA direction: 0 means B-to-A write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   dmaDir <= 1'b0;
    else if (strobe.restoreAll)  dmaDir <= 1'b0;
    else if (strobe.loadDmaDir)  dmaDir <= dmaDirIn;
  end

  always_comb begin
    statusWord     = '0;
    statusWord[3]  = dmaDir;
    statusWord[4]  = flagIn[FLG_AB_EMPTY];
    statusWord[5]  = flagIn[FLG_AB_AEMPTY];
    statusWord[6]  = flagIn[FLG_BA_FULL];
    statusWord[7]  = flagIn[FLG_BA_AFULL];
    statusWord[12] = flagIn[FLG_AB_FULL];
    statusWord[13] = flagIn[FLG_AB_AFULL];
    statusWord[14] = flagIn[FLG_BA_EMPTY];
    statusWord[15] = flagIn[FLG_BA_AEMPTY];
  end

  assign rdData = rdStatus ? statusWord : regVal[addr];
endmodule

// File: rtl/cfgRegBank.sv
module cfgRegBank
  import cfgbank_pkg::*;
#(
  parameter int               OFFSET_W      = 10,
  parameter logic [REG_W-1:0] ROUTE_DEFAULT = 16'h6420
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [REG_W-1:0]          wrData,
  input  logic                      swRstValid,
  input  logic [2:0]                swRstCode,
  input  logic                      dmaReqSet,
  input  logic                      dmaDirLoad,
  input  logic                      dmaDirIn,
  input  logic [NUM_FLAGS-1:0]      flagIn,
  input  logic                      rdStatus,
  output logic [REG_W-1:0]          rdData,
  output logic [NUM_REGS*REG_W-1:0] cfgFlat,
  output logic                      dmaReq,
  output logic                      dmaDir,
  output logic                      clrAbPtr,
  output logic                      clrBaPtr
);
  ctrlStrobe_t strobe;

  cfgbank_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (addr),
    .swRstValid (swRstValid),
    .swRstCode  (swRstCode),
    .dmaReqSet  (dmaReqSet),
    .dmaDirLoad (dmaDirLoad),
    .strobe     (strobe),
    .clrAbPtr   (clrAbPtr),
    .clrBaPtr   (clrBaPtr)
  );

  cfgbank_data #(
    .OFFSET_W      (OFFSET_W),
    .ROUTE_DEFAULT (ROUTE_DEFAULT)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .dmaDirIn (dmaDirIn),
    .flagIn   (flagIn),
    .addr     (addr),
    .rdStatus (rdStatus),
    .rdData   (rdData),
    .cfgFlat  (cfgFlat),
    .dmaReq   (dmaReq),
    .dmaDir   (dmaDir)
  );
endmodule

// File: rtl/cfgbank_checker.sv
module cfgbank_checker
  import cfgbank_pkg::*;
#(
  parameter int               OFFSET_W      = 10,
  parameter logic [REG_W-1:0] ROUTE_DEFAULT = 16'h6420
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic                      swRstValid,
  input logic [2:0]                swRstCode,
  input logic                      dmaReqSet,
  input logic                      dmaDirLoad,
  input logic                      rdStatus,
  input logic [REG_W-1:0]          rdData,
  input logic [NUM_REGS*REG_W-1:0] cfgFlat,
  input logic                      dmaReq,
  input logic                      dmaDir,
  input logic                      clrAbPtr,
  input logic                      clrBaPtr
);
  logic offHigh;
  logic cmdBa, cmdAb, cmdBoth, cmdReq, cmdAll, cmdNop;

  always_comb begin
    offHigh = 1'b0;
    for (int i = 0; i < NUM_OFFSET_REGS; i++)
      offHigh = offHigh || (cfgFlat[i*REG_W+OFFSET_W +: REG_W-OFFSET_W] != '0);
  end

  assign cmdBa   = swRstValid && swRstCode == 3'b001;
  assign cmdAb   = swRstValid && swRstCode == 3'b010;
  assign cmdBoth = swRstValid && swRstCode == 3'b011;
  assign cmdReq  = swRstValid && swRstCode == 3'b100;
  assign cmdAll  = swRstValid && swRstCode == 3'b111;
  assign cmdNop  = (!swRstValid || swRstCode == 3'b000 || swRstCode == 3'b101 || swRstCode == 3'b110)
                   && !wrEn && !dmaReqSet && !dmaDirLoad;

  AST_OFFSET_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN) !offHigh); // R2
  AST_BA_ONLY: assert property (@(posedge clk) disable iff (!rstN) cmdBa |=> clrBaPtr && !clrAbPtr); // R3
  AST_AB_ONLY: assert property (@(posedge clk) disable iff (!rstN) cmdAb |=> clrAbPtr && !clrBaPtr); // R4
  AST_BOTH_PTR: assert property (@(posedge clk) disable iff (!rstN) cmdBoth |=> clrAbPtr && clrBaPtr); // R5
  AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN) cmdReq |=> !dmaReq && !clrAbPtr && !clrBaPtr); // R6
  AST_ALL_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    cmdAll |=> cfgFlat[ROUTE_REG_IDX*REG_W +: REG_W] == ROUTE_DEFAULT && !dmaReq && !dmaDir && clrAbPtr && clrBaPtr); // R7
  AST_NOP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdNop |=> $stable(cfgFlat) && $stable(dmaReq) && $stable(dmaDir) && !clrAbPtr && !clrBaPtr); // R8
  AST_STATUS_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus |-> (rdData & 16'h0F07) == 16'h0000); // R9
  AST_REQ_SET: assert property (@(posedge clk) disable iff (!rstN)
    dmaReqSet && !cmdReq && !cmdAll |=> dmaReq); // R11
  AST_PARTIAL_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBa || cmdAb || cmdBoth || cmdReq) && !wrEn |=> $stable(cfgFlat)); // R12
endmodule

bind cfgRegBank cfgbank_checker #(
  .OFFSET_W      (OFFSET_W),
  .ROUTE_DEFAULT (ROUTE_DEFAULT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .swRstValid (swRstValid),
  .swRstCode  (swRstCode),
  .dmaReqSet  (dmaReqSet),
  .dmaDirLoad (dmaDirLoad),
  .rdStatus   (rdStatus),
  .rdData     (rdData),
  .cfgFlat    (cfgFlat),
  .dmaReq     (dmaReq),
  .dmaDir     (dmaDir),
  .clrAbPtr   (clrAbPtr),
  .clrBaPtr   (clrBaPtr)
);

// File: tb/cfgRegBank_bench.sv
`timescale 1ns/1ps
module cfgRegBank_bench;
  localparam int          OW    = 10;
  localparam logic [15:0] ROUTE = 16'h6420;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wrData = '0;
  logic swRstValid = 1'b0;
  logic [2:0] swRstCode = '0;
  logic dmaReqSet = 1'b0;
  logic dmaDirLoad = 1'b0;
  logic dmaDirIn = 1'b0;
  logic [7:0] flagIn = '0;
  logic rdStatus = 1'b0;
  logic [15:0] rdData;
  logic [127:0] cfgFlat;
  logic dmaReq, dmaDir, clrAbPtr, clrBaPtr;

  int vecCount = 0;
  int failCount = 0;
  bit done = 0;

  logic [15:0] mdl [8];
  logic mdlReq, mdlDir, expAb, expBa;

  always #2.5 clk = ~clk;

  cfgRegBank u_cfgRegBank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .swRstValid(swRstValid), .swRstCode(swRstCode), .dmaReqSet(dmaReqSet),
    .dmaDirLoad(dmaDirLoad), .dmaDirIn(dmaDirIn), .flagIn(flagIn),
    .rdStatus(rdStatus), .rdData(rdData), .cfgFlat(cfgFlat), .dmaReq(dmaReq),
    .dmaDir(dmaDir), .clrAbPtr(clrAbPtr), .clrBaPtr(clrBaPtr)
  );

  function automatic logic [15:0] maskFn(input logic [2:0] a, input logic [15:0] d);
    return (a < 3'd4) ? (d & 16'h03FF) : d;
  endfunction

  function automatic logic [15:0] statusFn(input logic [7:0] f, input logic dir);
    logic [15:0] s = '0;
    s[3] = dir;  s[4] = f[0];  s[5] = f[1];  s[12] = f[2]; s[13] = f[3];
    s[14] = f[4]; s[15] = f[5]; s[6] = f[6]; s[7] = f[7];
    return s;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mdlDefaults();
    for (int i = 0; i < 8; i++) mdl[i] = (i == 4) ? ROUTE : 16'h0000;
    mdlReq = 1'b0;
    mdlDir = 1'b0;
  endtask

  function automatic logic [127:0] mdlFlat();
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = mdl[i];
    return v;
  endfunction

  task automatic compareAll(input string tag);
    chk({tag, " words"}, cfgFlat, mdlFlat());
    chk({tag, " dma"}, {126'd0, dmaReq, dmaDir}, {126'd0, mdlReq, mdlDir});
    chk({tag, " strobes"}, {126'd0, clrAbPtr, clrBaPtr}, {126'd0, expAb, expBa});
    if (rdStatus) chk({tag, " status R9"}, {112'd0, rdData}, {112'd0, statusFn(flagIn, mdlDir)});
    else          chk({tag, " read R10"}, {112'd0, rdData}, {112'd0, mdl[addr]});
  endtask

  // drive at negedge, step one edge, compare at the next negedge
  task automatic cycle(input logic w, input logic [2:0] a, input logic [15:0] d,
                       input logic sv, input logic [2:0] sc, input logic rs,
                       input logic dl, input logic di, input logic [7:0] f,
                       input logic st, input string tag);
    bit isAll, isReq;
    wrEn = w; addr = a; wrData = d; swRstValid = sv; swRstCode = sc;
    dmaReqSet = rs; dmaDirLoad = dl; dmaDirIn = di; flagIn = f; rdStatus = st;
    isAll = sv && sc == 3'b111;
    isReq = sv && sc == 3'b100;
    expBa = sv && (sc == 3'b001 || sc == 3'b011 || sc == 3'b111);
    expAb = sv && (sc == 3'b010 || sc == 3'b011 || sc == 3'b111);
    if (isAll) mdlDefaults();
    else begin
      if (w) mdl[a] = maskFn(a, d);
      if (isReq) mdlReq = 1'b0;
      else if (rs) mdlReq = 1'b1;
      if (dl) mdlDir = di;
    end
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    cycle(0, addr, 16'h0, 0, 3'b000, 0, 0, 0, flagIn, 0, tag);
  endtask

  task automatic hwReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 0; swRstValid = 0; dmaReqSet = 0; dmaDirLoad = 0; rdStatus = 0;
    mdlDefaults();
    expAb = 1'b1; expBa = 1'b1;
    #1;
    compareAll("R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    #1;
    compareAll("R1 released before edge");
    idle("R1 first edge");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    hwReset();

    // R2 offset masking and full-width words
    cycle(1, 3'd0, 16'hFFFF, 0, 0, 0, 0, 0, 8'h00, 0, "R2 offset mask");
    cycle(1, 3'd5, 16'hBEEF, 0, 0, 0, 0, 0, 8'h00, 0, "R2 full word");
    cycle(1, 3'd4, 16'h1234, 0, 0, 0, 0, 0, 8'h00, 0, "R2 route word");
    // R11 request and direction
    cycle(0, 3'd5, 0, 0, 0, 1, 1, 1, 8'h00, 0, "R11 set req load dir");
    // R6 clear wins over set, dir kept
    cycle(0, 3'd5, 0, 1, 3'b100, 1, 0, 0, 8'h00, 0, "R6 clear beats set");
    // R3 R4 R5 with writes in same cycle (R12)
    cycle(1, 3'd1, 16'h02AA, 1, 3'b001, 0, 0, 0, 8'h00, 0, "R3 R12 ba clear with write");
    idle("R3 strobe drops");
    cycle(1, 3'd6, 16'h5A5A, 1, 3'b010, 0, 0, 0, 8'h00, 0, "R4 R12 ab clear with write");
    cycle(0, 3'd6, 0, 1, 3'b011, 0, 0, 0, 8'h00, 0, "R5 both clear");
    // R8 unused codes
    cycle(0, 3'd6, 0, 1, 3'b101, 0, 0, 0, 8'h00, 0, "R8 code 101");
    cycle(0, 3'd6, 0, 1, 3'b110, 0, 0, 0, 8'h00, 0, "R8 code 110");
    cycle(0, 3'd6, 0, 1, 3'b000, 0, 0, 0, 8'h00, 0, "R8 code 000");
    // R9 status patterns
    cycle(0, 3'd0, 0, 0, 0, 0, 0, 0, 8'h01, 1, "R9 single flag");
    cycle(0, 3'd0, 0, 0, 0, 0, 0, 0, 8'hFF, 1, "R9 all flags");
    cycle(0, 3'd0, 0, 0, 0, 1, 1, 1, 8'hA5, 1, "R9 dir bit");
    // R7 reset-all beats write and direction load
    cycle(1, 3'd4, 16'hFFFF, 1, 3'b111, 1, 1, 1, 8'h00, 0, "R7 all beats write");
    idle("R7 strobe drops");

    for (int n = 0; n < 3000; n++) begin
      logic sv;
      logic [2:0] sc;
      string tag;
      sv = ($urandom % 8) == 0;
      sc = 3'($urandom);
      if (sc == 3'b111 && ($urandom % 3) != 0) sc = 3'b100;
      if (sv) begin
        case (sc)
          3'b001: tag = "R3 rand";
          3'b010: tag = "R4 rand";
          3'b011: tag = "R5 rand";
          3'b100: tag = "R6 rand";
          3'b111: tag = "R7 rand";
          default: tag = "R8 rand";
        endcase
      end else tag = "R2 R10 R11 R12 rand";
      cycle(1'($urandom), 3'($urandom), 16'($urandom), sv, sc,
            ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom),
            8'($urandom), ($urandom % 3) == 0, tag);
      if (n == 1500) hwReset();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule